// File: doc/BRIEF.md
# Signed Integer Divide Execution Unit

This unit sits in the execute stage of a 32-bit RISC core and handles a single register-format instruction: signed integer division. When the core raises a start strobe, the unit reads three things: the instruction word and two register operand values. It decodes the opcode and extended-opcode fields and, if they match, runs a restoring shift-subtract loop on the operand magnitudes. The loop produces one quotient bit per clock. At the end the unit corrects the sign and returns the destination register index together with a one-cycle done pulse.

Division by zero and the single overflow case never trap. Each returns a fixed value that software must not rely on. A build-time parameter can remove divide support. In that build a matching instruction raises a one-cycle unimplemented-instruction flag and produces no result.

Top module: `sdiv_exec_unit`

## Requirements
- R1: For every defined case, `quot_o` equals the signed quotient of `opa_i` by `opb_i`, truncated toward zero, with both operands read as two's-complement 32-bit integers.
- R2: An operation starts only when instruction bits 5:0 equal 0x3a and bits 16:11 equal 0x25. A start with any other value in either field produces neither `done_o` nor `unimpl_o`.
- R3: `dest_o` carries instruction bits 21:17 as captured at the accepted start. It is valid in the cycle `done_o` is high.
- R4: `done_o` first goes high in the cycle after the 32nd rising edge that follows the accepting edge. It stays high for exactly one cycle and is never high together with `unimpl_o`.
- R5: A start that arrives while an operation is in progress is ignored. The running operation keeps its operands and destination index, and no extra result is produced.
- R6: A zero divisor produces 0xFFFFFFFF and raises no `unimpl_o`.
- R7: A dividend of 0x80000000 divided by 0xFFFFFFFF (-1) produces 0x80000000 and raises no `unimpl_o`.
- R8: With `DIV_EN` = 0, a matching start raises `unimpl_o` for exactly one cycle, in the cycle after the accepting edge. In that cycle `dest_o` shows bits 21:17 and no `done_o` follows. With `DIV_EN` = 1, `unimpl_o` never rises.
- R9: After reset, `done_o`, `unimpl_o`, `quot_o` and `dest_o` are all zero.
- R10: For every defined case, the remainder (dividend minus quotient times divisor) is zero or has the sign of the dividend, and its magnitude is below the divisor's magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue strobe for the presented instruction |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | Dividend register value |
| opb_i | input | 32 | Divisor register value |
| dest_o | output | 5 | Destination register index |
| quot_o | output | 32 | Quotient |
| done_o | output | 1 | One-cycle result-valid pulse |
| unimpl_o | output | 1 | One-cycle unimplemented-instruction pulse |

## Verification
The bench targets the operand signs where truncation and flooring disagree. A design that floors, or that applies the sign as an OR instead of an XOR, returns a quotient one too negative or of the wrong sign. It also covers the minimum and maximum integers, a divisor larger than the dividend, a zero divisor and the overflow pair. Magnitude conversion slips show up on these values as wrong results, and a design that traps shows up as a stray `unimpl_o`. Further cases check that an instruction differing in only one decode field is rejected, and that a start issued mid-operation neither corrupts nor duplicates the result. A build without divide support must flag, and must not compute.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam logic [5:0] OPC_RTYPE = 6'h3a;
  localparam logic [5:0] OPX_SDIV  = 6'h25;

  typedef struct packed {
    logic [XLEN-1:0] rem;
    logic            qbit;
  } step_t;

  // two's-complement magnitude of a signed word
  function automatic logic [XLEN-1:0] mag_of(input logic [XLEN-1:0] v);
    return v[XLEN-1] ? (~v + 1'b1) : v;
  endfunction

  // one restoring step: shift in next dividend bit, try subtracting
  function automatic step_t div_step(input logic [XLEN-1:0] rem,
                                     input logic            nbit,
                                     input logic [XLEN-1:0] dvs);
    logic [XLEN:0] shifted;
    logic [XLEN:0] diff;
    step_t r;
    shifted = {rem, nbit};
    diff    = shifted - {1'b0, dvs};
    if (!diff[XLEN]) begin
      r.rem  = diff[XLEN-1:0];
      r.qbit = 1'b1;
    end else begin
      r.rem  = shifted[XLEN-1:0];
      r.qbit = 1'b0;
    end
    return r;
  endfunction

  // final sign correction and divide-by-zero substitution
  function automatic logic [XLEN-1:0] finish_q(input logic [XLEN-1:0] qmag,
                                               input logic            neg,
                                               input logic            zdiv);
    if (zdiv) return '1;
    return neg ? (~qmag + 1'b1) : qmag;
  endfunction
endpackage

// File: rtl/sdiv_decode.sv
module sdiv_decode
  import sdiv_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output logic            match_o,
  output logic [RIDX-1:0] rdst_o
);
  logic [5:0] op_w;
  logic [5:0] opx_w;
  logic       unused_fields;

  assign op_w   = instr_i[5:0];
  assign opx_w  = instr_i[16:11];
  assign rdst_o = instr_i[21:17];
  assign match_o = (op_w == OPC_RTYPE) && (opx_w == OPX_SDIV);
  // source indices and the spare field are consumed by the register file
  assign unused_fields = ^{instr_i[31:22], instr_i[10:6]};
endmodule

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep
  import sdiv_pkg::*;
(
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] dvd_mag_o,
  output logic [XLEN-1:0] dvs_mag_o,
  output logic            neg_o,
  output logic            zero_o
);
  assign dvd_mag_o = mag_of(opa_i);
  assign dvs_mag_o = mag_of(opb_i);
  assign neg_o     = opa_i[XLEN-1] ^ opb_i[XLEN-1];
  assign zero_o    = (opb_i == '0);
endmodule

// File: rtl/sdiv_iter_core.sv
module sdiv_iter_core
  import sdiv_pkg::*;
#(
  parameter int W = XLEN,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] dvd_mag_i,
  input  logic [W-1:0] dvs_mag_i,
  input  logic         neg_i,
  input  logic         zero_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quot_o
);
  logic [W-1:0]  rem_q, dvd_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q, neg_q, zero_q;
  logic [W-1:0]  quot_q;
  step_t         step_w;
  logic          last_w;
  logic [W-1:0]  qmag_w;

  assign step_w = div_step(rem_q, dvd_q[W-1], dvs_q);
  assign last_w = busy_q && (cnt_q == CW'(W-1));
  assign qmag_w = {dvd_q[W-2:0], step_w.qbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      quot_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q  <= '0;
        dvd_q  <= dvd_mag_i;
        dvs_q  <= dvs_mag_i;
        neg_q  <= neg_i;
        zero_q <= zero_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= step_w.rem;
        dvd_q <= qmag_w;
        cnt_q <= cnt_q + 1'b1;
        if (last_w) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
          quot_q <= finish_q(qmag_w, neg_q, zero_q);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = fin_q;
  assign quot_o = quot_q;

  // R4
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
  // R4
  fin_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> !busy_q && $past(busy_q));
  // R5
  dvs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(dvs_q) && $stable(neg_q));
  // R6
  zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && zero_q) |-> (quot_q == '1));
  // R10
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !zero_q && cnt_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/sdiv_exec_unit.sv
module sdiv_exec_unit
  import sdiv_pkg::*;
#(
  parameter bit DIV_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  output logic [4:0]  dest_o,
  output logic [31:0] quot_o,
  output logic        done_o,
  output logic        unimpl_o
);
  logic            match_w;
  logic [RIDX-1:0] rdst_w;
  logic [XLEN-1:0] dvd_mag_w, dvs_mag_w;
  logic            neg_w, zero_w;
  logic            busy_w, fin_w;
  logic [XLEN-1:0] core_q_w;
  logic            accept_w, launch_w, trap_w;
  logic [RIDX-1:0] dest_q;
  logic            trap_q;

  sdiv_decode u_dec (
    .instr_i (instr_i),
    .match_o (match_w),
    .rdst_o  (rdst_w)
  );

  sdiv_operand_prep u_prep (
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .dvd_mag_o (dvd_mag_w),
    .dvs_mag_o (dvs_mag_w),
    .neg_o     (neg_w),
    .zero_o    (zero_w)
  );

  assign accept_w = start_i && match_w && !busy_w;

  generate
    if (DIV_EN) begin : g_impl
      assign launch_w = accept_w;
      assign trap_w   = 1'b0;
    end else begin : g_noimpl
      assign launch_w = 1'b0;
      assign trap_w   = accept_w;
    end
  endgenerate

  sdiv_iter_core #(.W(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (launch_w),
    .dvd_mag_i (dvd_mag_w),
    .dvs_mag_i (dvs_mag_w),
    .neg_i     (neg_w),
    .zero_i    (zero_w),
    .busy_o    (busy_w),
    .fin_o     (fin_w),
    .quot_o    (core_q_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= trap_w;
      if (accept_w) dest_q <= rdst_w;
    end
  end

  assign dest_o   = dest_q;
  assign quot_o   = core_q_w;
  assign done_o   = fin_w;
  assign unimpl_o = trap_q;

  // R8
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |=> !unimpl_o);
  // R8
  no_trap_when_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    DIV_EN |-> !unimpl_o);
  // R4
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && unimpl_o));
  // R3
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !launch_w) |=> $stable(dest_o));
  // R2
  launch_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |-> (instr_i[5:0] == 6'h3a) && (instr_i[16:11] == 6'h25));
endmodule

// File: tb/sdiv_exec_unit_tb.sv
module sdiv_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start2 = 1'b0;
  logic [31:0] instr = '0, opa = '0, opb = '0;
  logic [4:0]  dest, dest2;
  logic [31:0] quot, quot2;
  logic        done, done2, unimpl, unimpl2;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdiv_exec_unit #(.DIV_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
    .opa_i(opa), .opb_i(opb), .dest_o(dest), .quot_o(quot),
    .done_o(done), .unimpl_o(unimpl));

  sdiv_exec_unit #(.DIV_EN(1'b0)) dut_nodiv_i (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .instr_i(instr),
    .opa_i(opa), .opb_i(opb), .dest_o(dest2), .quot_o(quot2),
    .done_o(done2), .unimpl_o(unimpl2));

  function automatic logic [31:0] mk(input logic [4:0] ra, rb, rc);
    return {ra, rb, rc, 6'h25, 5'd0, 6'h3a};
  endfunction

  // reference: language signed division truncates toward zero
  function automatic logic [31:0] ref_q(input logic [31:0] a, b);
    if (b == 0) return 32'hFFFF_FFFF;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
    return 32'($signed(a) / $signed(b));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] ins, a, b,
                        output logic [31:0] q, output logic [4:0] d, output int lat);
    @(negedge clk); instr = ins; opa = a; opb = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    q = quot; d = dest;
  endtask

  task automatic div_check(input logic [31:0] a, b, input string req);
    logic [31:0] q; logic [4:0] d; int lat;
    longint r, sa, sb, sq;
    run_op(mk(5'd7, 5'd8, 5'd6), a, b, q, d, lat);
    chk(lat == 32, req, 64'(lat), 64'd32);
    chk(q == ref_q(a, b), req, 64'(q), 64'(ref_q(a, b)));
    chk(!unimpl, req, 64'(unimpl), 64'd0);
    if (b != 0 && !(a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) begin
      sa = longint'($signed(a)); sb = longint'($signed(b)); sq = longint'($signed(q));
      r = sa - sq * sb;
      // R10
      chk((r == 0 || ((r < 0) == (sa < 0))) && ((r < 0 ? -r : r) < (sb < 0 ? -sb : sb)),
          "R10", 64'(r), 64'(sa));
    end
  endtask

  task automatic t_reset;
    // R9
    chk(done == 0 && unimpl == 0, "R9", {62'd0, done, unimpl}, 64'd0);
    chk(quot == 0 && dest == 0, "R9", {27'd0, dest, quot}, 64'd0);
  endtask

  task automatic t_signs;
    // R1 truncation across sign combinations
    div_check(32'd7, 32'd2, "R1");
    div_check(-32'sd7, 32'd2, "R1");
    div_check(32'd7, -32'sd2, "R1");
    div_check(-32'sd7, -32'sd2, "R1");
    div_check(32'd3, 32'd10, "R1");
    div_check(-32'sd3, 32'd10, "R1");
    div_check(32'd0, -32'sd5, "R1");
  endtask

  task automatic t_edges;
    div_check(32'h7FFF_FFFF, 32'd1, "R1");
    div_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, "R1");
    div_check(32'h8000_0000, 32'd1, "R1");
    div_check(32'h8000_0000, 32'h7FFF_FFFF, "R1");
    div_check(32'h8000_0000, 32'h8000_0000, "R1");
    div_check(32'h7FFF_FFFF, 32'h8000_0000, "R1");
    div_check(32'd1, 32'hFFFF_FFFF, "R1");
    div_check(32'h8000_0000, 32'd2, "R1");
  endtask

  task automatic t_special;
    div_check(32'd1234, 32'd0, "R6");
    div_check(32'h8000_0000, 32'd0, "R6");
    div_check(32'h8000_0000, 32'hFFFF_FFFF, "R7");
  endtask

  task automatic t_random;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? ($urandom & 32'h0000_FFFF) : $urandom;
      if (i % 4 == 1) b = {{16{b[15]}}, b[15:0]};
      div_check(a, b, "R1");
    end
  endtask

  task automatic t_dest_pulse;
    logic [31:0] q; logic [4:0] d; int lat;
    run_op(mk(5'd1, 5'd2, 5'd19), 32'd100, 32'd7, q, d, lat);
    // R3
    chk(d == 5'd19, "R3", 64'(d), 64'd19);
    chk(q == 32'd14, "R1", 64'(q), 64'd14);
    @(negedge clk);
    // R4
    chk(!done, "R4", 64'(done), 64'd0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    @(negedge clk); instr = mk(5'd3, 5'd4, 5'd9); opa = 32'd1000; opb = 32'd10; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; lat = 0;
    repeat (4) begin @(negedge clk); lat++; end
    instr = mk(5'd3, 5'd4, 5'd22); opa = 32'd50; opb = 32'd5; start = 1'b1;
    @(negedge clk); lat++; start = 1'b0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    // R5
    chk(lat == 32, "R5", 64'(lat), 64'd32);
    chk(quot == 32'd100, "R5", 64'(quot), 64'd100);
    chk(dest == 5'd9, "R5", 64'(dest), 64'd9);
    lat = 0;
    repeat (40) begin @(negedge clk); if (done) lat++; end
    chk(lat == 0, "R5", 64'(lat), 64'd0);
  endtask

  task automatic t_decode_miss;
    int seen;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      instr = (k == 0) ? {15'h1234, 6'h24, 5'd0, 6'h3a} : {15'h1234, 6'h25, 5'd0, 6'h3b};
      opa = 32'd9; opb = 32'd3; start = 1'b1;
      @(negedge clk); start = 1'b0; start2 = 1'b0;
      seen = 0;
      repeat (40) begin @(negedge clk); if (done || unimpl) seen++; end
      // R2
      chk(seen == 0, "R2", 64'(seen), 64'd0);
    end
    div_check(32'd9, 32'd3, "R2");
  endtask

  task automatic t_unimpl;
    int seen;
    @(negedge clk); instr = mk(5'd5, 5'd6, 5'd27); opa = 32'd8; opb = 32'd2; start2 = 1'b1;
    @(posedge clk);
    @(negedge clk); start2 = 1'b0;
    // R8
    chk(unimpl2 == 1'b1, "R8", 64'(unimpl2), 64'd1);
    chk(dest2 == 5'd27, "R8", 64'(dest2), 64'd27);
    @(negedge clk);
    chk(unimpl2 == 1'b0, "R8", 64'(unimpl2), 64'd0);
    seen = 0;
    repeat (40) begin @(negedge clk); if (done2) seen++; end
    chk(seen == 0, "R8", 64'(seen), 64'd0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dest_pulse();
    t_signs();
    t_edges();
    t_special();
    t_busy_ignore();
    t_decode_miss();
    t_unimpl();
    t_random();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule